// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of general-purpose I/O pins with a word-wide register port. For every pin it keeps an output value, a direction bit and a synchronized copy of the pad input. It also detects interrupt events on each pin. Each pin can be routed into the event logic and enabled onto an interrupt line. Its trigger can be set to a rising edge, a falling edge, a high level or a low level.

Detected events collect in a sticky status word. The bank raises an interrupt while any status bit that is also enabled is set. A build parameter can split the interrupt into two lines, one for the lower half of the pins and one for the upper half.

Software reaches every register through three addresses. One writes the register directly, one ORs the data into it, and one clears the bits where the data holds ones. The status word ignores direct writes and set writes, so it can only be acknowledged through its clear address.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, `padOe` and `padOut` are zero, and both interrupt lines are low.
- R2: The register index is `busAddr[6:4]`: 0 output data, 1 input data, 2 direction, 3 routing, 4 interrupt enable, 5 trigger mode, 6 trigger polarity, 7 status. A direct write (alias `busAddr[3:2]`=0) loads the word. `padOut` follows the output-data register and `padOe` follows the direction register, where bit n = 1 makes pin n an output.
- R3: For any register, a write with alias 1 sets only the bits where the data is 1 and a write with alias 2 clears only those bits. A write with alias 3 changes nothing. Reads at any alias return the register's value.
- R4: The input-data register returns `padIn` delayed by a two-flop synchronizer, so a pad change is visible on the second clock edge after it, and writes to this register have no effect.
- R5: With the mode bit at 0, a polarity bit of 1 selects a rising edge and 0 selects a falling edge. An edge sets the status bit once and does not set it again while the pad holds still. The per-pin code is {polarity, mode}: 00 falling, 10 rising, 01 low level, 11 high level.
- R6: With the mode bit at 1, the status bit is set on every cycle that the selected level is present, so a clear issued while the level persists leaves the bit set.
- R7: A pin's status bit is set only while its routing bit is 1.
- R8: Direct writes and set writes to the status register have no effect. A clear write removes the selected bits, and an all-ones clear removes every pending bit.
- R9: An interrupt line is high exactly when its pins have a bit set in both status and interrupt enable. Clearing the enable drops the line and leaves the status bit pending.
- R10: With the split enabled (default), pins 16 to 31 drive `irqHigh` and pins 0 to 15 drive `irqMain`. Without the split, every pin drives `irqMain` and `irqHigh` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 7 | Byte address: register index in [6:4], alias in [3:2] |
| busWe | input | 1 | Write strobe for the current address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current address |
| padIn | input | 32 | Asynchronous pad inputs |
| padOut | output | 32 | Output data to pads |
| padOe | output | 32 | Per-pin output enable |
| irqMain | output | 1 | Interrupt for the lower half (or for all pins when unsplit) |
| irqHigh | output | 1 | Interrupt for the upper half |

## Verification
The bench clears a level-triggered pin while its level is still present. A design in which the clear wins would drop the status bit, when the bit should come straight back. It holds an edge-triggered pad still after acknowledging it, which exposes detection that compares against a stale sample and fires again. It writes direct and set values to status and to the input register, which catches decoders that let such writes through. It moves pins 15 and 16 on each side of the interrupt split, which catches an off-by-one in the half boundary. It routes a pin without enabling it and enables a pin without routing it, to show that the routing gate and the enable mask are two separate stages.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NUM_REGS  = 8;
  localparam int REG_IDX_W = $clog2(NUM_REGS);
  localparam int IDX_LSB   = 4;
  localparam int ALIAS_LSB = 2;
  localparam int DEC_W     = IDX_LSB + REG_IDX_W;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_DOUT  = 3'd0,
    REG_DIN   = 3'd1,
    REG_OE    = 3'd2,
    REG_ROUTE = 3'd3,
    REG_IEN   = 3'd4,
    REG_TMODE = 3'd5,
    REG_TPOL  = 3'd6,
    REG_STAT  = 3'd7
  } regIdx_e;

  typedef enum logic [1:0] {
    AL_WRITE = 2'd0,
    AL_SET   = 2'd1,
    AL_CLR   = 2'd2,
    AL_NONE  = 2'd3
  } alias_e;

  typedef struct packed {
    logic [NUM_REGS-1:0]  wrDirect;
    logic [NUM_REGS-1:0]  wrSet;
    logic [NUM_REGS-1:0]  wrClr;
    logic [REG_IDX_W-1:0] rdIdx;
  } bankStrobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output bankStrobe_t       strb
);
  logic                 hiZero;
  logic [REG_IDX_W-1:0] idx;
  alias_e               al;

  generate
    if (ADDR_W > DEC_W) begin : g_hi
      assign hiZero = ~|busAddr[ADDR_W-1:DEC_W];
    end else begin : g_nohi
      assign hiZero = 1'b1;
    end
  endgenerate

  assign idx = busAddr[IDX_LSB +: REG_IDX_W];
  assign al  = alias_e'(busAddr[ALIAS_LSB +: 2]);

  always_comb begin
    strb       = '0;
    strb.rdIdx = idx;
    if (busWe && hiZero) begin
      unique case (al)
        AL_WRITE: strb.wrDirect[idx] = 1'b1;
        AL_SET:   strb.wrSet[idx]    = 1'b1;
        AL_CLR:   strb.wrClr[idx]    = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] dinVal
);
  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= '0;
    end else begin
      stageQ[0] <= padIn;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign dinVal = stageQ[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] warmCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) warmCnt <= '0;
        else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
      end
      // R4
      din_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
        (warmCnt >= 2'd2) |-> (dinVal == $past(padIn, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  bankStrobe_t     strb,
  input  logic [PINS-1:0] busWdata,
  input  logic [PINS-1:0] dinVal,
  output logic [PINS-1:0] busRdata,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOe,
  output logic [PINS-1:0] pendVec
);
  logic [PINS-1:0] regFile [NUM_REGS];
  logic [PINS-1:0] prevQ;
  logic [PINS-1:0] riseVec, fallVec, levelHit, edgeHit, evtVec;
  logic [PINS-1:0] modeVec, polVec, routeVec, ienVec, statQ;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      if (g == int'(REG_DIN)) begin : g_din
        assign regFile[g] = dinVal;
      end else if (g == int'(REG_STAT)) begin : g_stat
        logic [PINS-1:0] q;
        logic [PINS-1:0] clrMask;
        assign clrMask = strb.wrClr[g] ? busWdata : '0;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) q <= '0;
          else       q <= (q & ~clrMask) | (evtVec & routeVec);
        end
        assign regFile[g] = q;
      end else begin : g_rw
        logic [PINS-1:0] q;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)                q <= '0;
          else if (strb.wrDirect[g]) q <= busWdata;
          else if (strb.wrSet[g])    q <= q | busWdata;
          else if (strb.wrClr[g])    q <= q & ~busWdata;
        end
        assign regFile[g] = q;
      end
    end
  endgenerate

  assign padOut   = regFile[REG_DOUT];
  assign padOe    = regFile[REG_OE];
  assign routeVec = regFile[REG_ROUTE];
  assign ienVec   = regFile[REG_IEN];
  assign modeVec  = regFile[REG_TMODE];
  assign polVec   = regFile[REG_TPOL];
  assign statQ    = regFile[REG_STAT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= dinVal;
  end

  assign riseVec  = dinVal & ~prevQ;
  assign fallVec  = ~dinVal & prevQ;
  assign levelHit = (dinVal & polVec) | (~dinVal & ~polVec);
  assign edgeHit  = (riseVec & polVec) | (fallVec & ~polVec);
  assign evtVec   = (modeVec & levelHit) | (~modeVec & edgeHit);

  assign pendVec  = statQ & ienVec;
  assign busRdata = regFile[strb.rdIdx];

  // R8
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrClr[REG_STAT] |=> ((statQ & $past(statQ)) == $past(statQ)));

  // R7
  stat_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statQ & ~$past(statQ) & ~$past(routeVec)) == '0));

  // R6
  evt_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(evtVec) & $past(routeVec)) & ~statQ) == '0));

  // R3
  set_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSet[REG_DOUT] |=> ((padOut & $past(busWdata)) == $past(busWdata)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS      = 32,
  parameter int ADDR_W    = 7,
  parameter int SYNC_DEPTH = 2,
  parameter bit SPLIT_IRQ = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [PINS-1:0]   busWdata,
  output logic [PINS-1:0]   busRdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic              irqMain,
  output logic              irqHigh
);
  localparam int HALF = PINS / 2;

  bankStrobe_t     strb;
  logic [PINS-1:0] dinVal;
  logic [PINS-1:0] pendVec;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb)
  );

  gpio_bank_sync #(.WIDTH(PINS), .STAGES(SYNC_DEPTH)) sync_i (
    .clk    (clk),
    .rstN   (rstN),
    .padIn  (padIn),
    .dinVal (dinVal)
  );

  gpio_bank_datapath #(.PINS(PINS)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .dinVal   (dinVal),
    .busRdata (busRdata),
    .padOut   (padOut),
    .padOe    (padOe),
    .pendVec  (pendVec)
  );

  generate
    if (SPLIT_IRQ) begin : g_split
      assign irqMain = |pendVec[HALF-1:0];
      assign irqHigh = |pendVec[PINS-1:HALF];
    end else begin : g_single
      assign irqMain = |pendVec;
      assign irqHigh = 1'b0;
    end
  endgenerate
endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb_top;
  localparam int A_DOUT = 0, A_DIN = 1, A_OE = 2, A_ROUTE = 3, A_IEN = 4,
                 A_MODE = 5, A_POL = 6, A_STAT = 7;
  localparam int K_RD = 0, K_IRQ = 1, K_POUT = 2, K_POE = 3;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOe;
  logic        irqMain, irqHigh;

  int    checks = 0;
  int    errors = 0;
  bit    chkPend = 1'b0;
  bit    done = 1'b0;
  item_t sbq[$];

  always #4 clk = ~clk;

  gpio_irq_bank dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .irqMain(irqMain), .irqHigh(irqHigh)
  );

  function automatic logic [6:0] addrOf(int idx, int al);
    return 7'(idx * 16 + al * 4);
  endfunction

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(int idx, int al, logic [31:0] d);
    busAddr = addrOf(idx, al); busWdata = d; busWe = 1'b1;
    @(posedge clk); #2;
    busWe = 1'b0;
  endtask

  task automatic push(int kind, int idx, int al, logic [31:0] e, string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    busAddr = addrOf(idx, al);
    sbq.push_back(it);
    chkPend = 1'b1;
    @(posedge clk); #2;
    chkPend = 1'b0;
  endtask

  task automatic rd(int idx, logic [31:0] e, string tag);
    push(K_RD, idx, 0, e, tag);
  endtask

  task automatic irqChk(logic hi, logic mn, string tag);
    push(K_IRQ, 0, 0, {30'd0, hi, mn}, tag);
  endtask

  task automatic pad(logic [31:0] v);
    padIn = v; cyc(3);
  endtask

  always @(negedge clk) begin
    if (chkPend && sbq.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = sbq.pop_front();
      case (it.kind)
        K_RD:    got = busRdata;
        K_IRQ:   got = {30'd0, irqHigh, irqMain};
        K_POUT:  got = padOut;
        default: got = padOe;
      endcase
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s got %h exp %h", it.tag, got, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    for (int i = 0; i < 8; i++) rd(i, 32'h0, "R1 reset register");
    irqChk(1'b0, 1'b0, "R1 reset irq");
    push(K_POE, 0, 0, 32'h0, "R1 reset padOe");
    push(K_POUT, 0, 0, 32'h0, "R1 reset padOut");

    // R2 direct writes
    wr(A_DOUT, 0, 32'hA5A5_0F0F);
    rd(A_DOUT, 32'hA5A5_0F0F, "R2 dout readback");
    push(K_POUT, 0, 0, 32'hA5A5_0F0F, "R2 padOut");
    wr(A_OE, 0, 32'hFFFF_0000);
    push(K_POE, 0, 0, 32'hFFFF_0000, "R2 padOe");

    // R3 aliases
    wr(A_DOUT, 1, 32'h0000_F0F0);
    rd(A_DOUT, 32'hA5A5_FFFF, "R3 set alias");
    wr(A_DOUT, 2, 32'hA500_000F);
    rd(A_DOUT, 32'h00A5_FFF0, "R3 clear alias");
    wr(A_DOUT, 3, 32'hFFFF_FFFF);
    push(K_RD, A_DOUT, 1, 32'h00A5_FFF0, "R3 alias 3 ignored, read via set alias");
    wr(A_OE, 2, 32'hFFFF_FFFF);
    push(K_POE, 0, 0, 32'h0, "R3 clear all oe");

    // R4 synchronizer latency and write immunity
    padIn = 32'h1234_5678;
    cyc(1);
    rd(A_DIN, 32'h0, "R4 din before second edge");
    rd(A_DIN, 32'h1234_5678, "R4 din after second edge");
    wr(A_DIN, 0, 32'hFFFF_FFFF);
    rd(A_DIN, 32'h1234_5678, "R4 din write ignored");
    // R7 unrouted activity leaves status clear
    rd(A_STAT, 32'h0, "R7 unrouted pins");
    pad(32'h0);
    rd(A_STAT, 32'h0, "R7 unrouted falling pins");

    // R5 rising edge on pin 3
    wr(A_POL, 1, 32'h8);
    wr(A_ROUTE, 1, 32'h8);
    wr(A_IEN, 1, 32'h8);
    cyc(2);
    rd(A_STAT, 32'h0, "R5 no event while still");
    pad(32'h8);
    rd(A_STAT, 32'h8, "R5 rising edge");
    irqChk(1'b0, 1'b1, "R9 main raised");
    wr(A_STAT, 2, 32'h8);
    rd(A_STAT, 32'h0, "R5 edge not retriggered");
    irqChk(1'b0, 1'b0, "R9 main dropped");

    // R5 falling edge on pin 5
    wr(A_ROUTE, 1, 32'h20);
    wr(A_IEN, 1, 32'h20);
    pad(32'h28);
    rd(A_STAT, 32'h0, "R5 rise ignored by falling trigger");
    pad(32'h08);
    rd(A_STAT, 32'h20, "R5 falling edge");
    // R8 direct and set writes to status ignored
    wr(A_STAT, 0, 32'hFFFF_FFFF);
    wr(A_STAT, 1, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h20, "R8 status write ignored");
    wr(A_STAT, 2, 32'h20);
    rd(A_STAT, 32'h0, "R8 status cleared");

    // R6 high level on pin 20
    wr(A_MODE, 1, 32'h0010_0000);
    wr(A_POL, 1, 32'h0010_0000);
    wr(A_ROUTE, 1, 32'h0010_0000);
    wr(A_IEN, 1, 32'h0010_0000);
    pad(32'h0010_0008);
    rd(A_STAT, 32'h0010_0000, "R6 high level");
    irqChk(1'b1, 1'b0, "R10 pin 20 on high line");
    wr(A_STAT, 2, 32'h0010_0000);
    rd(A_STAT, 32'h0010_0000, "R6 level reasserts after clear");
    pad(32'h8);
    wr(A_STAT, 2, 32'h0010_0000);
    rd(A_STAT, 32'h0, "R6 cleared after level gone");
    irqChk(1'b0, 1'b0, "R9 high line dropped");

    // R6 low level on pin 9, R9 masking
    wr(A_MODE, 1, 32'h200);
    wr(A_ROUTE, 1, 32'h200);
    cyc(1);
    rd(A_STAT, 32'h200, "R6 low level");
    irqChk(1'b0, 1'b0, "R9 pending but not enabled");
    wr(A_IEN, 1, 32'h200);
    irqChk(1'b0, 1'b1, "R9 enabled pending");
    wr(A_IEN, 2, 32'h200);
    irqChk(1'b0, 1'b0, "R9 masked");
    rd(A_STAT, 32'h200, "R9 status kept when masked");

    // R8 all-ones clear
    pad(32'h0);
    pad(32'h8);
    pad(32'h208);
    rd(A_STAT, 32'h208, "R8 two pending");
    wr(A_STAT, 2, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h0, "R8 all-ones clear");

    // R10 split boundary
    wr(A_POL, 1, 32'h0001_8000);
    wr(A_ROUTE, 1, 32'h0001_8000);
    wr(A_IEN, 1, 32'h0001_8000);
    pad(32'h0001_0208);
    rd(A_STAT, 32'h0001_0000, "R10 pin 16 event");
    irqChk(1'b1, 1'b0, "R10 pin 16 on high line");
    wr(A_STAT, 2, 32'h0001_0000);
    pad(32'h0001_8208);
    rd(A_STAT, 32'h0000_8000, "R10 pin 15 event");
    irqChk(1'b0, 1'b1, "R10 pin 15 on main line");
    wr(A_STAT, 2, 32'hFFFF_FFFF);

    // R7 enabled but unrouted
    wr(A_ROUTE, 2, 32'h8);
    pad(32'h0001_8200);
    pad(32'h0001_8208);
    rd(A_STAT, 32'h0, "R7 unrouted pin 3");
    irqChk(1'b0, 1'b0, "R7 no irq when unrouted");

    cyc(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule